// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory from power-on to its operating state. After reset it holds the clock enable low and the command bus idle for the long power-up wait. It then raises the clock enable and walks a fixed list of commands: precharge of all banks, the three extended mode registers, the main mode register with DLL reset, a second precharge, two auto-refresh commands, and the final mode register write. It ends with the output-driver default and exit writes. Each command is followed by only NOP cycles until its recovery time has passed. The waits are computed at elaboration from a clock-period parameter and from nanosecond, microsecond and clock-count timing parameters.

The operating fields of the mode registers come in as static configuration inputs. These are burst length, burst order, CAS latency, write recovery, additive latency and output drive strength. The block places each field at its fixed bit position. Once the sequence is complete the block raises a done flag and keeps the bus at NOP with the clock enable high, so that the normal controller can take over the command pins. On-die termination is held off throughout. A reset at any point returns the block to the start of the power-up wait.

Top module: `ddr2_init_seq`

## Requirements
- R1: During reset, and for the power-up wait after reset release, the block drives the clock enable low, drives the bus as NOP and keeps done low. The power-up wait lasts ceil(PWRUP_US*1e6/CLK_PS) cycles and starts in the second clock cycle after rst_n deasserts, because the release passes through two synchronizer flops.
- R2: The clock enable rises exactly when the power-up wait ends and then stays high until the next reset. No command other than NOP is issued while it is low. After it rises, only NOP is issued for ceil(CKE_HOLD_NS*1000/CLK_PS) cycles.
- R3: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP=0111, precharge=0010, auto-refresh=0001, mode register write=0000. A precharge-all drives address bit 10 high, with every other address bit and the bank address at 0.
- R4: After the first precharge-all, the block writes extended register 2 with bank address 3'b010 and then extended register 3 with bank address 3'b011. Both writes use an all-zero address.
- R5: The DLL-enable write goes to bank address 3'b001. It has address bit 0 low (DLL on), bit 1 equal to the weak-drive input, bits 5:3 equal to the additive latency, bits 9:7 equal to 000, and every other bit 0.
- R6: The main mode register (bank 3'b000) is written twice. The first write comes right after DLL enable and has bit 8 high. The second write comes after the refreshes and has bit 8 low. Both writes carry bits 2:0 = 011 for burst 8 or 010 for burst 4, bit 3 = interleaved order, bits 6:4 = CAS latency, bits 11:9 = write recovery, and every other bit 0.
- R7: After the DLL-reset write, the block issues a second precharge-all and then two auto-refresh commands.
- R8: The output-driver default write goes to bank 3'b001 with bits 9:7 = 111. It is issued at the later of two cycles: tMRD after the second main-register write, or DLL_LOCK_CK cycles after the DLL-enable write. The exit write follows tMRD later with bits 9:7 = 000. Both writes keep the other fields from R5.
- R9: The next command comes exactly tMRD cycles after each mode register write, ceil(TRP_NS*1000/CLK_PS) cycles after each precharge-all, and ceil(TRFC_NS*1000/CLK_PS) cycles after each auto-refresh. Every gap is at least 2 cycles, and every cycle between commands is NOP with all address and bank bits 0.
- R10: ODT is low in every cycle.
- R11: Done rises tMRD cycles after the exit write and stays high until reset. While done is high, the bus is NOP with the clock enable high.
- R12: Asserting rst_n at any point immediately forces the clock enable low, the bus to NOP and done low. The next release restarts the whole sequence from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_bl8 | input | 1 | Burst length select: 1 = 8, 0 = 4 |
| cfg_interleave | input | 1 | Burst order: 1 = interleaved, 0 = sequential |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_wr_rec | input | 3 | Write recovery code |
| cfg_add_lat | input | 3 | Additive latency code |
| cfg_weak_drv | input | 1 | Output drive strength: 1 = reduced |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BANK_W | Bank address |
| ddr_addr | output | ROW_W | Address / mode register opcode |
| ddr_odt | output | 1 | On-die termination enable, held low |
| init_done | output | 1 | Initialization complete |

## Verification
The hardest situation to reach is a reset that lands inside the DLL lock wait. At that point the main-register writes and refreshes are already done, but the output-driver default write is still being held back by the lock count rather than by tMRD. The bench runs a full sequence with one configuration, then a second sequence that it interrupts about sixty cycles after the DLL-enable write. It checks at once that the outputs are back in their reset state. It then releases reset with a third configuration and compares every cycle of the fresh sequence against its own event list. This shows that no timer or field value survives from the interrupted run.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  // Sequence positions, in issue order; the order is behaviour.
  typedef enum logic [3:0] {
    ST_PWR_WAIT = 4'd0,
    ST_CKE_ON   = 4'd1,
    ST_PRE_A    = 4'd2,
    ST_EMR2     = 4'd3,
    ST_EMR3     = 4'd4,
    ST_EMR1_DLL = 4'd5,
    ST_MR_RST   = 4'd6,
    ST_PRE_B    = 4'd7,
    ST_REF_A    = 4'd8,
    ST_REF_B    = 4'd9,
    ST_MR_OP    = 4'd10,
    ST_OCD_DFLT = 4'd11,
    ST_OCD_EXIT = 4'd12,
    ST_READY    = 4'd13
  } step_e;

  // Recovery class that follows each step.
  typedef enum logic [2:0] {
    GAP_PWR  = 3'd0,
    GAP_CKE  = 3'd1,
    GAP_RP   = 3'd2,
    GAP_RFC  = 3'd3,
    GAP_MRD  = 3'd4,
    GAP_NONE = 3'd5
  } gap_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dram_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam dram_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam dram_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  typedef struct packed {
    logic       bl8;
    logic       interleave;
    logic [2:0] cas_lat;
    logic [2:0] wr_rec;
    logic [2:0] add_lat;
    logic       weak_drv;
  } mode_cfg_t;

endpackage

// File: rtl/ddr2_init_rstsync.sv
module ddr2_init_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ddr2_init_downcnt.sv
module ddr2_init_downcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec_en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  // The count never wraps from zero to the top value.
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '0 && !$past(load)) |-> (cnt_q == '0));

endmodule

// File: rtl/ddr2_init_cmdgen.sv
module ddr2_init_cmdgen
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ROW_W  = 14,
  parameter int unsigned BANK_W = 3
) (
  input  step_e             step,
  input  logic              issue,
  input  mode_cfg_t         cfg,
  output dram_cmd_t         cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output gap_e              gap
);

  function automatic logic [ROW_W-1:0] main_word(input mode_cfg_t c, input logic dll_rst);
    logic [ROW_W-1:0] w;
    w        = '0;
    w[2:0]   = c.bl8 ? 3'b011 : 3'b010;
    w[3]     = c.interleave;
    w[6:4]   = c.cas_lat;
    w[8]     = dll_rst;
    w[11:9]  = c.wr_rec;
    return w;
  endfunction

  function automatic logic [ROW_W-1:0] ext1_word(input mode_cfg_t c, input logic [2:0] ocd);
    logic [ROW_W-1:0] w;
    w        = '0;
    w[1]     = c.weak_drv;
    w[5:3]   = c.add_lat;
    w[9:7]   = ocd;
    return w;
  endfunction

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    gap  = GAP_NONE;
    unique case (step)
      ST_PWR_WAIT: gap = GAP_PWR;
      ST_CKE_ON:   gap = GAP_CKE;
      ST_PRE_A, ST_PRE_B: begin
        gap = GAP_RP;
        if (issue) begin
          cmd      = CMD_PRE;
          addr[10] = 1'b1;
        end
      end
      ST_EMR2: begin
        gap = GAP_MRD;
        if (issue) begin
          cmd = CMD_MRS;
          ba  = BANK_W'(2);
        end
      end
      ST_EMR3: begin
        gap = GAP_MRD;
        if (issue) begin
          cmd = CMD_MRS;
          ba  = BANK_W'(3);
        end
      end
      ST_EMR1_DLL, ST_OCD_DFLT, ST_OCD_EXIT: begin
        gap = GAP_MRD;
        if (issue) begin
          cmd  = CMD_MRS;
          ba   = BANK_W'(1);
          addr = ext1_word(cfg, (step == ST_OCD_DFLT) ? 3'b111 : 3'b000);
        end
      end
      ST_MR_RST, ST_MR_OP: begin
        gap = GAP_MRD;
        if (issue) begin
          cmd  = CMD_MRS;
          addr = main_word(cfg, step == ST_MR_RST);
        end
      end
      ST_REF_A, ST_REF_B: begin
        gap = GAP_RFC;
        if (issue) cmd = CMD_REF;
      end
      default: gap = GAP_NONE;
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CLK_PS      = 2500,
  parameter int unsigned PWRUP_US    = 200,
  parameter int unsigned CKE_HOLD_NS = 400,
  parameter int unsigned TRP_NS      = 15,
  parameter int unsigned TRFC_NS     = 128,
  parameter int unsigned TMRD_CK     = 2,
  parameter int unsigned DLL_LOCK_CK = 200,
  parameter int unsigned ROW_W       = 14,
  parameter int unsigned BANK_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bl8,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [2:0]        cfg_wr_rec,
  input  logic [2:0]        cfg_add_lat,
  input  logic              cfg_weak_drv,
  output logic              ddr_cke,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BANK_W-1:0] ddr_ba,
  output logic [ROW_W-1:0]  ddr_addr,
  output logic              ddr_odt,
  output logic              init_done
);

  function automatic int unsigned cyc_of_ps(input int unsigned ps);
    int unsigned c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 2) ? 2 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned G_PWR = cyc_of_ps(PWRUP_US * 1000 * 1000);
  localparam int unsigned G_CKE = cyc_of_ps(CKE_HOLD_NS * 1000);
  localparam int unsigned G_RP  = cyc_of_ps(TRP_NS * 1000);
  localparam int unsigned G_RFC = cyc_of_ps(TRFC_NS * 1000);
  localparam int unsigned G_MRD = (TMRD_CK < 2) ? 2 : TMRD_CK;
  localparam int unsigned G_MAX = max2(max2(G_PWR, G_CKE), max2(max2(G_RP, G_RFC), G_MRD));
  localparam int unsigned CW    = $clog2(G_MAX + 1);
  localparam int unsigned DW    = $clog2(DLL_LOCK_CK + 1);

  logic      rst_sync_n;
  step_e     step_q, step_d;
  logic      issue_q, issue_d;
  logic      gap_ld, gap_dec, dll_ld;
  logic [CW-1:0] gap_cnt, gap_val;
  logic [DW-1:0] dll_cnt;
  gap_e      gap_cls;
  dram_cmd_t cmd;
  mode_cfg_t cfg;
  logic      dll_gate;

  assign cfg = '{bl8: cfg_bl8, interleave: cfg_interleave, cas_lat: cfg_cas_lat,
                 wr_rec: cfg_wr_rec, add_lat: cfg_add_lat, weak_drv: cfg_weak_drv};

  ddr2_init_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ddr2_init_cmdgen #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_cmd (
    .step  (step_q),
    .issue (issue_q),
    .cfg   (cfg),
    .cmd   (cmd),
    .ba    (ddr_ba),
    .addr  (ddr_addr),
    .gap   (gap_cls)
  );

  ddr2_init_downcnt #(.W(CW)) u_gap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (gap_ld),
    .load_val (gap_val - 1'b1),
    .dec_en   (gap_dec),
    .count    (gap_cnt)
  );

  ddr2_init_downcnt #(.W(DW)) u_dll (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (dll_ld),
    .load_val (DW'(DLL_LOCK_CK - 1)),
    .dec_en   (1'b1),
    .count    (dll_cnt)
  );

  always_comb begin
    unique case (gap_cls)
      GAP_PWR: gap_val = CW'(G_PWR);
      GAP_CKE: gap_val = CW'(G_CKE);
      GAP_RP:  gap_val = CW'(G_RP);
      GAP_RFC: gap_val = CW'(G_RFC);
      GAP_MRD: gap_val = CW'(G_MRD);
      default: gap_val = CW'(2);
    endcase
  end

  // The driver default write waits for the DLL lock count as well.
  assign dll_gate = (step_q == ST_MR_OP);

  always_comb begin
    step_d  = step_q;
    issue_d = issue_q;
    gap_ld  = 1'b0;
    gap_dec = 1'b0;
    dll_ld  = 1'b0;
    if (step_q != ST_READY) begin
      if (issue_q) begin
        issue_d = 1'b0;
        gap_ld  = 1'b1;
        dll_ld  = (step_q == ST_EMR1_DLL);
      end else if (gap_cnt > CW'(1)) begin
        gap_dec = 1'b1;
      end else if (!dll_gate || (dll_cnt <= DW'(1))) begin
        step_d  = step_e'(step_q + 4'd1);
        issue_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      step_q  <= ST_PWR_WAIT;
      issue_q <= 1'b1;
    end else begin
      step_q  <= step_d;
      issue_q <= issue_d;
    end
  end

  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd;
  assign ddr_cke   = (step_q != ST_PWR_WAIT);
  assign ddr_odt   = 1'b0;
  assign init_done = (step_q == ST_READY);

  // Checker-side age of the DLL-enable write, saturating at the lock count.
  logic [DW-1:0] lock_age;
  logic          lock_run;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lock_age <= '0;
      lock_run <= 1'b0;
    end else if (step_q == ST_EMR1_DLL && issue_q) begin
      lock_age <= DW'(1);
      lock_run <= 1'b1;
    end else if (lock_run && (lock_age < DW'(DLL_LOCK_CK))) begin
      lock_age <= lock_age + 1'b1;
    end
  end

  assert_cmd_needs_cke_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd != CMD_NOP) |-> ddr_cke);

  assert_cke_held_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(ddr_cke) |-> ddr_cke);

  assert_nop_follows_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

  assert_dll_lock_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd == CMD_MRS && ddr_addr[9:7] == 3'b111) |-> (lock_age >= DW'(DLL_LOCK_CK)));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(init_done) |-> init_done);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    init_done |-> (cmd == CMD_NOP && ddr_cke));

endmodule

// File: tb/sim_ddr2_init_seq.sv
module sim_ddr2_init_seq;

  localparam int CLK_PS   = 10000;
  localparam int P_PWR    = (200 * 1000 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int P_CKE    = (400 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int P_RP     = (15 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int P_RFC    = (128 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int P_MRD    = 2;
  localparam int P_DLL    = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        c_bl8, c_il, c_wdrv;
  logic [2:0]  c_cl, c_wr, c_al;
  logic        cke, cs_n, ras_n, cas_n, we_n, odt, done;
  logic [2:0]  ba;
  logic [13:0] addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Expected plan: cycle index, packed {cmd, ba, addr}, requirement tag.
  int          ev_k[$];
  logic [20:0] ev_v[$];
  string       ev_tag[$];
  int          k_cke, k_done, k_dll, ptr;

  always #5 clk = ~clk;

  ddr2_init_seq #(.CLK_PS(CLK_PS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_bl8(c_bl8), .cfg_interleave(c_il), .cfg_cas_lat(c_cl),
    .cfg_wr_rec(c_wr), .cfg_add_lat(c_al), .cfg_weak_drv(c_wdrv),
    .ddr_cke(cke), .ddr_cs_n(cs_n), .ddr_ras_n(ras_n), .ddr_cas_n(cas_n),
    .ddr_we_n(we_n), .ddr_ba(ba), .ddr_addr(addr), .ddr_odt(odt),
    .init_done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] main_exp(input logic dllr);
    logic [13:0] a = '0;
    a[2:0] = c_bl8 ? 3'b011 : 3'b010;
    a[3] = c_il; a[6:4] = c_cl; a[8] = dllr; a[11:9] = c_wr;
    return a;
  endfunction

  function automatic logic [13:0] ext1_exp(input logic [2:0] ocd);
    logic [13:0] a = '0;
    a[1] = c_wdrv; a[5:3] = c_al; a[9:7] = ocd;
    return a;
  endfunction

  task automatic add_ev(input int k, input logic [3:0] c, input logic [2:0] b,
                        input logic [13:0] a, input string tag);
    ev_k.push_back(k); ev_v.push_back({c, b, a}); ev_tag.push_back(tag);
  endtask

  task automatic build_plan();
    int k;
    ev_k.delete(); ev_v.delete(); ev_tag.delete();
    k = 2 + P_PWR;
    k_cke = k;
    k += P_CKE;  add_ev(k, 4'b0010, 3'd0, 14'h0400, "R3");
    k += P_RP;   add_ev(k, 4'b0000, 3'd2, 14'h0, "R4");
    k += P_MRD;  add_ev(k, 4'b0000, 3'd3, 14'h0, "R4");
    k += P_MRD;  add_ev(k, 4'b0000, 3'd1, ext1_exp(3'b000), "R5");
    k_dll = k;
    k += P_MRD;  add_ev(k, 4'b0000, 3'd0, main_exp(1'b1), "R6");
    k += P_MRD;  add_ev(k, 4'b0010, 3'd0, 14'h0400, "R7");
    k += P_RP;   add_ev(k, 4'b0001, 3'd0, 14'h0, "R7");
    k += P_RFC;  add_ev(k, 4'b0001, 3'd0, 14'h0, "R7");
    k += P_RFC;  add_ev(k, 4'b0000, 3'd0, main_exp(1'b0), "R6");
    k = (k + P_MRD > k_dll + P_DLL) ? k + P_MRD : k_dll + P_DLL;
    add_ev(k, 4'b0000, 3'd1, ext1_exp(3'b111), "R8");
    k += P_MRD;  add_ev(k, 4'b0000, 3'd1, ext1_exp(3'b000), "R8");
    k_done = k + P_MRD;
    ptr = 0;
  endtask

  task automatic check_cycle(input int k);
    logic [20:0] act, exp;
    string tag;
    act = {cs_n, ras_n, cas_n, we_n, ba, addr};
    if (ptr < ev_k.size() && ev_k[ptr] == k) begin
      exp = ev_v[ptr]; tag = ev_tag[ptr]; ptr++;
    end else begin
      exp = {4'b0111, 3'd0, 14'd0};
      tag = (k < k_cke) ? "R1" : (k >= k_done) ? "R11" : "R9";
    end
    check(act == exp, tag, act, exp);
    check(cke == (k >= k_cke), (k < k_cke) ? "R1" : "R2", 21'(cke), 21'(k >= k_cke));
    check(done == (k >= k_done), "R11", 21'(done), 21'(k >= k_done));
    check(odt == 1'b0, "R10", 21'(odt), 21'd0);
  endtask

  task automatic run_to(input int last);
    for (int k = 1; k <= last; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_cycle(k);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check(cke == 1'b0, tag, 21'(cke), 21'd0);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, tag, 21'({cs_n, ras_n, cas_n, we_n}), 21'b0111);
    check(done == 1'b0, tag, 21'(done), 21'd0);
    check(odt == 1'b0, "R10", 21'(odt), 21'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    c_bl8 = 1'b1; c_il = 1'b0; c_cl = 3'd5; c_wr = 3'd4; c_al = 3'd0; c_wdrv = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    build_plan();
    rst_n = 1'b1;
    run_to(k_done + 20);

    // Second run, interrupted inside the DLL lock wait (R12).
    @(negedge clk);
    rst_n = 1'b0;
    c_bl8 = 1'b0; c_il = 1'b1; c_cl = 3'd4; c_wr = 3'd2; c_al = 3'd3; c_wdrv = 1'b1;
    repeat (3) @(negedge clk);
    build_plan();
    rst_n = 1'b1;
    run_to(k_dll + 60);
    rst_n = 1'b0;
    #1;
    check_reset_state("R12");

    // Third run restarts from scratch with new fields (R12, R5, R6, R8).
    repeat (3) @(negedge clk);
    c_bl8 = 1'b1; c_il = 1'b1; c_cl = 3'd6; c_wr = 3'd7; c_al = 3'd5; c_wdrv = 1'b1;
    build_plan();
    rst_n = 1'b1;
    run_to(k_done + 20);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule